// File: doc/BRIEF.md
# Seeded LFSR Slot Scheduler

This block sets the reply slot of a passive tag in a framed slotted ALOHA inventory. On a start request it seeds a 16-bit linear feedback shift register with the tag's stored 16-bit CRC. The register then steps once per clock for a run whose length comes from the tag ID. The run ends at the first zero command bit from the reader, or when the step budget is used up, whichever comes first. The frozen value is loaded into a 16-bit down counter that decrements on slot ticks. A one-cycle transmit grant is raised when the counter reaches zero.

Because the seed and the run length differ from tag to tag, and the reader's first zero bit arrives at a point that no tag controls, tags in the same field end up waiting different numbers of slots. The block covers only this timing. The transmission and the handling of acknowledgements belong to the surrounding logic.

Top module: `slot_sched`

## Requirements
- R1: After a synchronous active-high reset, grant_o is 0 and the block is idle, so slot ticks and command bits cause no grant until a start is accepted.
- R2: A start_i pulse while idle captures seed_i as the register's initial value. A seed of zero is replaced by 16'h0001. The same pulse captures a step budget of run_len_i + 1.
- R3: Each step shifts the register left by one bit and inserts into bit 0 the XOR of bits 15, 13, 12 and 10, which is the polynomial x^16+x^14+x^13+x^11+1.
- R4: While the register runs, a cycle with rx_valid_i=1 and rx_bit_i=0 stops it without a step in that cycle. Valid bits of value 1 do not stop it.
- R5: If no zero bit arrives, the register stops after exactly run_len_i + 1 steps. A zero bit in the same cycle as exhaustion gives the same value.
- R6: The stopped value is loaded into the slot down counter. Slot ticks that arrive before the load do not change the outcome.
- R7: For a loaded value N, grant_o goes to 1 for exactly one cycle, one clock after the N-th slot tick that follows the load, and stays 0 before that.
- R8: start_i is ignored while the register runs or the counter counts. Command bits are ignored outside the run.
- R9: After a grant the block returns to idle, and further slot ticks raise no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new slot draw (accepted when idle) |
| seed_i | input | 16 | Stored CRC used as the register seed |
| run_len_i | input | 8 | Low ID bits; the budget is this value plus one steps |
| rx_valid_i | input | 1 | A reader command bit is present |
| rx_bit_i | input | 1 | Value of the reader command bit |
| slot_tick_i | input | 1 | One pulse per slot boundary |
| grant_o | output | 1 | One-cycle transmit grant |

## Verification
The two stop causes can land in the same cycle: the reader's first zero bit can arrive exactly when the step budget runs out. The bench provokes this with a directed draw whose zero bit is timed to the budget's last cycle. It also uses random draws whose stop offset crosses the budget in both directions. In each case the slot count is predicted from a bench model of min(stop offset, budget) steps, and the bench checks that the grant appears exactly after that many ticks. Slot ticks and a competing start are also driven during the run, to show that they do not shift the result.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_COUNT = 2'd2
  } sched_state_t;
endpackage

// File: rtl/ss_lfsr.sv
module ss_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] NONZERO = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] state_q;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign value_o = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= NONZERO;
    end else if (load_i) begin
      state_q <= (seed_i == '0) ? NONZERO : seed_i;
    end else if (step_i) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end
endmodule

// File: rtl/ss_budget.sv
module ss_budget #(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [RUN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             empty_o
);
  localparam int CW = RUN_W + 1;

  logic [CW-1:0] left_q;

  assign empty_o = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= {1'b0, len_i} + CW'(1);
    end else if (dec_i && !empty_o) begin
      left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/ss_slot_cnt.sv
module ss_slot_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  input  logic         tick_i,
  output logic         last_o,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  assign count_o = cnt_q;
  assign last_o  = (cnt_q <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= value_i;
    end else if (tick_i && !last_o) begin
      cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int W     = 16,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [W-1:0]     seed_i,
  input  logic [RUN_W-1:0] run_len_i,
  input  logic             rx_valid_i,
  input  logic             rx_bit_i,
  input  logic             slot_tick_i,
  output logic             grant_o
);
  sched_state_t state_q;
  logic         begin_draw;
  logic         zero_bit;
  logic         budget_empty;
  logic         freeze;
  logic         step;
  logic         cnt_tick;
  logic         cnt_last;
  logic [W-1:0] lfsr_val;
  logic [W-1:0] cnt_val;

  always_comb begin
    begin_draw = (state_q == ST_IDLE) && start_i;
    zero_bit   = rx_valid_i && !rx_bit_i;
    freeze     = (state_q == ST_RUN) && (zero_bit || budget_empty);
    step       = (state_q == ST_RUN) && !freeze;
    cnt_tick   = (state_q == ST_COUNT) && slot_tick_i;
  end

  ss_lfsr #(.W(W)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .load_i (begin_draw),
    .seed_i (seed_i),
    .step_i (step),
    .value_o(lfsr_val)
  );

  ss_budget #(.RUN_W(RUN_W)) u_budget (
    .clk    (clk),
    .rst    (rst),
    .load_i (begin_draw),
    .len_i  (run_len_i),
    .dec_i  (step),
    .empty_o(budget_empty)
  );

  ss_slot_cnt #(.W(W)) u_slot (
    .clk    (clk),
    .rst    (rst),
    .load_i (freeze),
    .value_i(lfsr_val),
    .tick_i (cnt_tick),
    .last_o (cnt_last),
    .count_o(cnt_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      grant_o <= 1'b0;
    end else begin
      grant_o <= cnt_tick && cnt_last;
      unique case (state_q)
        ST_IDLE:  if (begin_draw) state_q <= ST_RUN;
        ST_RUN:   if (freeze) state_q <= ST_COUNT;
        ST_COUNT: if (cnt_tick && cnt_last) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk
  import slot_sched_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         slot_tick_i,
  input logic         grant_o,
  input sched_state_t state_q,
  input logic [W-1:0] lfsr_val,
  input logic [W-1:0] cnt_val
);
  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> !grant_o); // R7

  AST_GRANT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> ($past(slot_tick_i) && $past(state_q == ST_COUNT))); // R7

  AST_GRANT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> (state_q == ST_IDLE)); // R9

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (lfsr_val != '0)); // R2

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_COUNT) && !slot_tick_i) |=> $stable(cnt_val)); // R6

  AST_FROZEN_IN_COUNT: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_COUNT) && $past(state_q == ST_COUNT)) |-> $stable(lfsr_val)); // R4
endmodule

bind slot_sched slot_sched_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_tick_i(slot_tick_i),
  .grant_o    (grant_o),
  .state_q    (state_q),
  .lfsr_val   (lfsr_val),
  .cnt_val    (cnt_val)
);

// File: tb/test_slot_sched.sv
module test_slot_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic [7:0]  run_len_i = '0;
  logic        rx_valid_i = 1'b0;
  logic        rx_bit_i = 1'b1;
  logic        slot_tick_i = 1'b0;
  logic        grant_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  slot_sched i_slot_sched (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
    .run_len_i(run_len_i), .rx_valid_i(rx_valid_i), .rx_bit_i(rx_bit_i),
    .slot_tick_i(slot_tick_i), .grant_o(grant_o)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s); // R3
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [15:0] predict(input logic [15:0] seed, input int budget, input int stop_at);
    logic [15:0] v = (seed == 16'h0) ? 16'h0001 : seed;
    int n = (stop_at < budget) ? stop_at : budget;
    for (int k = 0; k < n; k++) v = lfsr_step(v);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One draw: stop bit raised after stop_at steps; ones_noise drives valid 1 bits.
  task automatic run_draw(input logic [15:0] seed, input logic [7:0] len, input int stop_at,
                          input bit ones_noise, input string tag);
    int budget = int'(len) + 1;
    logic [15:0] n_exp = predict(seed, budget, stop_at);
    int need = (n_exp == 0) ? 1 : int'(n_exp);
    int early = 0;
    int grant_at = -1;
    int grants = 0;
    @(negedge clk);
    start_i = 1'b1; seed_i = seed; run_len_i = len;
    @(negedge clk);
    start_i = 1'b0; seed_i = ~seed; run_len_i = ~len;
    for (int j = 0; j < stop_at && j < budget + 3; j++) begin
      rx_valid_i  = ones_noise;
      rx_bit_i    = 1'b1;
      slot_tick_i = (j < budget);   // R6: ticks during the run are ignored
      start_i     = (j == 0);       // R8: start while running is ignored
      @(negedge clk);
      if (grant_o) early++;
    end
    rx_valid_i = 1'b1; rx_bit_i = 1'b0; slot_tick_i = 1'b0; start_i = 1'b0;
    @(negedge clk);
    rx_valid_i = 1'b0; rx_bit_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (grant_o) early++;
    check({"R4/R5 no grant before load ", tag}, early, 0);
    for (int i = 1; i <= need + 2; i++) begin
      slot_tick_i = 1'b1;
      rx_valid_i  = (i == 1);       // R8: zero bit outside the run is ignored
      rx_bit_i    = 1'b0;
      start_i     = (i == 2);       // R8: start while counting is ignored
      @(negedge clk);
      if (grant_o) begin
        grants++;
        if (grant_at < 0) grant_at = i;
      end
    end
    slot_tick_i = 1'b0; rx_valid_i = 1'b0; rx_bit_i = 1'b1; start_i = 1'b0;
    check({"R7 grant tick index ", tag}, grant_at, need);
    check({"R7 single pulse ", tag}, grants, 1);
    grants = 0;
    for (int i = 0; i < 4; i++) begin
      slot_tick_i = 1'b1;
      @(negedge clk);
      if (grant_o) grants++;
    end
    slot_tick_i = 1'b0;
    check({"R9 idle after grant ", tag}, grants, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int got;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 grant low after reset", grant_o, 0);
    got = 0;
    for (int i = 0; i < 5; i++) begin
      slot_tick_i = 1'b1; rx_valid_i = 1'b1; rx_bit_i = 1'b0;
      @(negedge clk);
      if (grant_o) got++;
    end
    slot_tick_i = 1'b0; rx_valid_i = 1'b0; rx_bit_i = 1'b1;
    check("R1 idle ignores ticks", got, 0);

    run_draw(16'h0000, 8'd0, 5, 1'b0, "R2 zero seed");          // 1 -> 2
    run_draw(16'h0001, 8'd3, 2, 1'b1, "R4 stop mid run");       // 1->2->4
    run_draw(16'h0005, 8'd9, 0, 1'b0, "R4 stop at once");       // 5
    run_draw(16'h0003, 8'd5, 6, 1'b0, "R5 stop equals budget"); // both causes same cycle
    run_draw(16'h0003, 8'd2, 6, 1'b1, "R5 budget first");

    for (int t = 0; t < 10; t++) begin
      logic [15:0] s;
      logic [7:0]  l;
      int m;
      logic [15:0] n;
      do begin
        s = 16'($urandom);
        l = 8'($urandom % 256);
        m = int'($urandom % (int'(l) + 5));
        n = predict(s, int'(l) + 1, m);
      end while (n > 16'd3000);
      run_draw(s, l, m, 1'($urandom % 2), "R3 random");
    end
    finish_run();
  end
endmodule